// File: doc/BRIEF.md
# Sequenced SRAM Access Controller

This block sits between a simple request port and an asynchronous 64K x 8 memory made of two 32K x 8 static RAM banks. A client raises a read or write request with a 16-bit address and, for writes, an 8-bit data byte. The controller then walks the memory control lines through a fixed order, one phase per clock cycle. The address and write data are never changing while a bank is selected or while the write strobe is low.

The top address bit chooses the bank, and a bank is selected only while the memory enable is high. The low 15 address bits go to both banks. Read data settles while the enables are active and is captured on a clock edge. A one-cycle `done` pulse then reports it together with the captured byte. New requests are taken only while the controller is idle.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During and after reset the memory interface is idle: `mem_en`=0, `mem_oe_n`=1, `mem_we_n`=1, both `mem_cs_n` bits 1, `ready`=1 and `done`=0.
- R2: A write takes five one-cycle phases after its accepting edge, in this order. Phase 1 has all enables off. Phase 2 raises `mem_en`. Phase 3 drives `mem_we_n` low with `mem_en` high. Phase 4 returns `mem_we_n` high with `mem_en` still high. Phase 5 drops `mem_en`.
- R3: `mem_addr` does not change in any cycle in which a bank select is active or `mem_we_n` is low. It keeps the accepted address through all phases of a request.
- R4: `mem_cs_n[0]` (active low) selects the bank for address bit 15 = 0, and `mem_cs_n[1]` selects the bank for bit 15 = 1. Exactly one select is low while `mem_en` is high, and none is low while `mem_en` is low.
- R5: The controller drives the write byte onto `mem_data` in all five write phases and in no other cycle. During reads the bus carries only the memory's value.
- R6: A read takes three one-cycle phases. The setup phase has `mem_en`=0 and `mem_oe_n`=1. The open and capture phases both have `mem_en`=1 and `mem_oe_n`=0 with `mem_we_n`=1. At the end of the capture phase `rdata` takes the value on `mem_data`.
- R7: `done` is high for exactly one cycle. It is visible five cycles after the accepting edge of a write and three cycles after that of a read. `rdata` is valid while `done` is high after a read.
- R8: A request is accepted only when `req_valid` is high at a clock edge where `ready` is high. While the controller is busy, `req_valid`, `req_write`, `req_addr` and `req_wdata` have no effect: no extra `done` and no change of `mem_addr`.
- R9: `mem_addr` carries bits 14..0 of the accepted request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Byte to write |
| ready | output | 1 | Controller idle, request may be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte captured by the last read |
| mem_addr | output | 15 | Address to both banks |
| mem_data | inout | 8 | Memory data bus |
| mem_en | output | 1 | Memory enable, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_cs_n | output | 2 | Bank selects, active low, index = address bit 15 |

## Verification
The assertions watch several rules on every cycle. The address stays still under an active select. The write strobe sits inside the enable window and releases before the enable drops. At most one bank is selected, and none is selected when the memory is off. The write driver stays off while the output enable is low, and `done` never lasts two cycles. Only the bench's scenarios show the rest. These are the exact phase order and timing of each access, the data that lands in and returns from the bank model across the bank boundary, the latency of `done`, and that requests raised while busy are dropped.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_W_SETUP,
        ST_W_SEL,
        ST_W_STROBE,
        ST_W_RELEASE,
        ST_W_DESEL,
        ST_R_SETUP,
        ST_R_OPEN,
        ST_R_CAPT
    } seq_state_e;

    typedef struct packed {
        logic mem_en;
        logic oe_n;
        logic we_n;
        logic drive;
        logic capture;
        logic last;
    } ctrl_s;

    localparam ctrl_s CTRL_IDLE = '{mem_en: 1'b0, oe_n: 1'b1, we_n: 1'b1,
                                    drive: 1'b0, capture: 1'b0, last: 1'b0};

    function automatic ctrl_s ctrl_of(seq_state_e s);
        ctrl_s c;
        c = CTRL_IDLE;
        case (s)
            ST_W_SETUP:   c.drive = 1'b1;
            ST_W_SEL: begin
                c.drive  = 1'b1;
                c.mem_en = 1'b1;
            end
            ST_W_STROBE: begin
                c.drive  = 1'b1;
                c.mem_en = 1'b1;
                c.we_n   = 1'b0;
            end
            ST_W_RELEASE: begin
                c.drive  = 1'b1;
                c.mem_en = 1'b1;
            end
            ST_W_DESEL: begin
                c.drive = 1'b1;
                c.last  = 1'b1;
            end
            ST_R_OPEN: begin
                c.mem_en = 1'b1;
                c.oe_n   = 1'b0;
            end
            ST_R_CAPT: begin
                c.mem_en  = 1'b1;
                c.oe_n    = 1'b0;
                c.capture = 1'b1;
                c.last    = 1'b1;
            end
            default: c = CTRL_IDLE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    input  logic  req_write,
    output ctrl_s ctrl,
    output logic  accept,
    output logic  ready,
    output logic  done
);

    seq_state_e state_q, state_d;
    logic       done_q;

    always_comb ctrl = ctrl_of(state_q);

    assign ready  = (state_q == ST_IDLE);
    assign accept = ready && req_valid;
    assign done   = done_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:      if (req_valid) state_d = req_write ? ST_W_SETUP : ST_R_SETUP;
            ST_W_SETUP:   state_d = ST_W_SEL;
            ST_W_SEL:     state_d = ST_W_STROBE;
            ST_W_STROBE:  state_d = ST_W_RELEASE;
            ST_W_RELEASE: state_d = ST_W_DESEL;
            ST_W_DESEL:   state_d = ST_IDLE;
            ST_R_SETUP:   state_d = ST_R_OPEN;
            ST_R_OPEN:    state_d = ST_R_CAPT;
            ST_R_CAPT:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= ctrl.last;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_STROBE_IN_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !ctrl.we_n |-> (ctrl.mem_en && $past(ctrl.mem_en))); // R2

    AST_STROBE_RELEASE_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.we_n) |-> ctrl.mem_en); // R2

    AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !ctrl.oe_n |-> ctrl.we_n); // R6

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ready); // R8

endmodule

// File: rtl/sram_seq_hold.sv
module sram_seq_hold #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= bus_in;
        end
    end

endmodule

// File: rtl/sram_bank_dec.sv
module sram_bank_dec #(
    parameter int BANK_BITS = 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mem_en,
    input  logic [BANK_BITS-1:0]    bank_sel,
    output logic [(1<<BANK_BITS)-1:0] cs_n
);

    localparam int NUM_BANKS = 1 << BANK_BITS;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign cs_n[g] = !(mem_en && (bank_sel == BANK_BITS'(g)));
    end

    AST_ONE_BANK_ON: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> ($countones(~cs_n) == 1)); // R4

    AST_NO_BANK_OFF: assert property (@(posedge clk) disable iff (rst)
        !mem_en |-> (&cs_n)); // R4

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int BANK_BITS = 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    output logic                          ready,
    output logic                          done,
    output logic [DATA_W-1:0]             rdata,
    output logic [ADDR_W-BANK_BITS-1:0]   mem_addr,
    inout  wire  [DATA_W-1:0]             mem_data,
    output logic                          mem_en,
    output logic                          mem_oe_n,
    output logic                          mem_we_n,
    output logic [(1<<BANK_BITS)-1:0]     mem_cs_n
);

    localparam int BANK_ADDR_W = ADDR_W - BANK_BITS;
    localparam int NUM_BANKS   = 1 << BANK_BITS;

    ctrl_s             ctrl;
    logic              accept;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    sram_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .ctrl      (ctrl),
        .accept    (accept),
        .ready     (ready),
        .done      (done)
    );

    sram_seq_hold #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_hold (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (ctrl.capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_in    (mem_data),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rdata_q   (rdata)
    );

    sram_bank_dec #(
        .BANK_BITS (BANK_BITS)
    ) u_dec (
        .clk      (clk),
        .rst      (rst),
        .mem_en   (ctrl.mem_en),
        .bank_sel (addr_q[ADDR_W-1:BANK_ADDR_W]),
        .cs_n     (mem_cs_n)
    );

    assign mem_addr = addr_q[BANK_ADDR_W-1:0];
    assign mem_en   = ctrl.mem_en;
    assign mem_oe_n = ctrl.oe_n;
    assign mem_we_n = ctrl.we_n;
    assign mem_data = ctrl.drive ? wdata_q : {DATA_W{1'bz}};

    AST_ADDR_HELD_SELECTED: assert property (@(posedge clk) disable iff (rst)
        (mem_cs_n != {NUM_BANKS{1'b1}}) |-> $stable(mem_addr)); // R3

    AST_ADDR_HELD_STROBE: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> $stable(addr_q)); // R3

    AST_DRIVE_NOT_READING: assert property (@(posedge clk) disable iff (rst)
        ctrl.drive |-> mem_oe_n); // R5

    AST_DRIVE_OUTLASTS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl.drive) |-> ($past(!mem_en) && $past(mem_we_n))); // R5

endmodule

// File: tb/sram_seq_ctrl_test.sv
module sram_seq_ctrl_test;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        bit         is_read;
        logic [7:0] data;
        int         due;
        logic [15:0] addr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr  = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, done;
    logic [7:0]  rdata;
    logic [14:0] mem_addr;
    wire  [7:0]  mem_data;
    logic        mem_en, mem_oe_n, mem_we_n;
    logic [1:0]  mem_cs_n;

    int vectors    = 0;
    int miscompares = 0;
    int cyc        = 0;

    exp_t       sb_q[$];
    logic [7:0] ref_mem  [logic [15:0]];
    logic [7:0] bank_mem [logic [15:0]];

    sram_seq_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ready     (ready),
        .done      (done),
        .rdata     (rdata),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .mem_en    (mem_en),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_cs_n  (mem_cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // behavioural two-bank static RAM
    logic [15:0] bank_key;
    logic        sram_oe;
    logic [7:0]  sram_q;
    always @(*) begin
        bank_key = {!mem_cs_n[1], mem_addr};
        sram_oe  = (mem_cs_n != 2'b11) && !mem_oe_n && mem_we_n;
        sram_q   = bank_mem.exists(bank_key) ? bank_mem[bank_key] : 8'h00;
    end
    assign mem_data = sram_oe ? sram_q : 8'hzz;

    always @(posedge mem_we_n) begin
        if (mem_cs_n != 2'b11) bank_mem[{!mem_cs_n[1], mem_addr}] = mem_data;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [1:0] sel_n(logic [15:0] a);
        return a[15] ? 2'b01 : 2'b10;
    endfunction

    // driver: issues one request, checks each phase, pushes the expected result
    task automatic do_req(bit wr, logic [15:0] a, logic [7:0] d, bit poke);
        exp_t e;
        @(negedge clk);
        chk("R8 ready before request", ready, 1'b1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        if (poke) begin
            req_write = !wr; req_addr = ~a; req_wdata = ~d;
        end else begin
            req_valid = 1'b0;
        end
        e.is_read = !wr;
        e.addr    = a;
        e.due     = cyc + (wr ? 5 : 3);
        if (wr) begin
            ref_mem[a] = d;
            e.data = d;
        end else begin
            e.data = ref_mem.exists(a) ? ref_mem[a] : 8'h00;
        end
        sb_q.push_back(e);
        if (wr) begin
            chk("R2 ph1 mem_en", mem_en, 1'b0);
            chk("R2 ph1 we_n", mem_we_n, 1'b1);
            chk("R4 ph1 no select", mem_cs_n, 2'b11);
            chk("R5 ph1 data", mem_data, d);
            chk("R9 address bits", mem_addr, a[14:0]);
            @(negedge clk);
            chk("R2 ph2 mem_en", mem_en, 1'b1);
            chk("R2 ph2 we_n", mem_we_n, 1'b1);
            chk("R4 ph2 bank select", mem_cs_n, sel_n(a));
            @(negedge clk);
            chk("R2 ph3 we_n low", mem_we_n, 1'b0);
            chk("R2 ph3 mem_en", mem_en, 1'b1);
            chk("R5 ph3 data", mem_data, d);
            @(negedge clk);
            chk("R2 ph4 we_n high", mem_we_n, 1'b1);
            chk("R2 ph4 mem_en", mem_en, 1'b1);
            chk("R5 ph4 data", mem_data, d);
            chk("R3 ph4 address", mem_addr, a[14:0]);
            @(negedge clk);
            chk("R2 ph5 mem_en off", mem_en, 1'b0);
            chk("R4 ph5 no select", mem_cs_n, 2'b11);
            chk("R3 ph5 address", mem_addr, a[14:0]);
            chk("R8 busy", ready, 1'b0);
        end else begin
            chk("R6 setup mem_en", mem_en, 1'b0);
            chk("R6 setup oe_n", mem_oe_n, 1'b1);
            chk("R9 address bits", mem_addr, a[14:0]);
            @(negedge clk);
            chk("R6 open mem_en", mem_en, 1'b1);
            chk("R6 open oe_n", mem_oe_n, 1'b0);
            chk("R4 read bank select", mem_cs_n, sel_n(a));
            chk("R5 bus carries memory only", mem_data, e.data);
            @(negedge clk);
            chk("R6 capt oe_n", mem_oe_n, 1'b0);
            chk("R6 capt we_n", mem_we_n, 1'b1);
            chk("R3 capt address", mem_addr, a[14:0]);
            chk("R8 busy", ready, 1'b0);
        end
        req_valid = 1'b0;
    endtask

    // monitor: pops expected completions as done appears
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                if (sb_q.size() == 0) begin
                    chk("R8 unexpected done", 1'b1, 1'b0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk("R7 done latency", cyc, e.due);
                    if (e.is_read) chk("R6 read data", rdata, e.data);
                end
            end else if (sb_q.size() != 0 && sb_q[0].due <= cyc) begin
                chk("R7 missing done", 1'b0, 1'b1);
                void'(sb_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset mem_en", mem_en, 1'b0);
        chk("R1 reset oe_n", mem_oe_n, 1'b1);
        chk("R1 reset we_n", mem_we_n, 1'b1);
        chk("R1 reset selects", mem_cs_n, 2'b11);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle ready", ready, 1'b1);
        chk("R1 idle done", done, 1'b0);
        chk("R1 idle selects", mem_cs_n, 2'b11);

        // bank boundaries
        do_req(1'b1, 16'h0000, 8'h3C, 1'b0);
        do_req(1'b1, 16'h7FFF, 8'hA5, 1'b0);
        do_req(1'b1, 16'h8000, 8'h5A, 1'b0);
        do_req(1'b1, 16'hFFFF, 8'hC3, 1'b0);
        do_req(1'b0, 16'h7FFF, 8'h00, 1'b0);
        do_req(1'b0, 16'h8000, 8'h00, 1'b0);
        do_req(1'b0, 16'h0000, 8'h00, 1'b0);
        do_req(1'b0, 16'hFFFF, 8'h00, 1'b0);
        do_req(1'b0, 16'h1234, 8'h00, 1'b0);
        // requests held high while busy must be ignored (R8)
        do_req(1'b1, 16'h7FFF, 8'h96, 1'b1);
        do_req(1'b0, 16'h7FFF, 8'h00, 1'b1);
        do_req(1'b0, 16'h8000, 8'h00, 1'b1);
        // write data differing from memory, then reads (R5 bus sharing)
        do_req(1'b1, 16'h4444, 8'hFF, 1'b0);
        do_req(1'b0, 16'h0000, 8'h00, 1'b0);
        // spread pattern
        for (int i = 0; i < 20; i++) begin
            do_req(1'b1, 16'(i * 16'h1357) ^ 16'h2468, 8'(i * 37 + 11), 1'b0);
        end
        for (int i = 0; i < 20; i++) begin
            do_req(1'b0, 16'(i * 16'h1357) ^ 16'h2468, 8'h00, (i % 3) == 0);
        end
        repeat (4) @(negedge clk);
        chk("R7 all completions seen", sb_q.size(), 0);
        chk("R1 back to idle", mem_cs_n, 2'b11);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule